// File: doc/BRIEF.md
# USB Transmit Endpoint Control

This block keeps the control and status state of one transmit endpoint in a USB function controller. Software sees two byte-wide registers behind a one-bit address: a control byte, which selects automatic packet arming, direction on a shared FIFO, DMA requests and the DMA interrupt granularity, and a status byte, which holds the packet-ready flag and the data toggle. The block counts bytes pushed into the transmit FIFO. When a packet of exactly the programmed maximum size has been loaded, it can arm the packet on its own.

The serializer reports a handshake with `ack_in`. The block then advances the data toggle, drops packet-ready and restarts the byte count. Software can also force a toggle advance and a FIFO flush at any time, without waiting for a handshake. The DMA engine is served by a request line that is high while the endpoint wants data. The block also counts the bytes of each DMA transfer against a configured length and raises one-cycle interrupt pulses, either for every packet or only when the whole transfer has completed.

Top module: `usb_txep_ctrl`

## Requirements
- R1: After reset the control byte, packet-ready, data toggle, byte counts, `dma_req`, `irq` and `fifo_flush` are all 0, and `ep_is_tx` is 1 while `shared_fifo` is 0.
- R2: With `csr_addr`=1 the control byte reads as bit 7 auto-arm, bit 5 direction, bit 4 DMA enable and bit 2 DMA interrupt mode. Bits 6, 3, 1 and 0 always read 0. With `csr_addr`=0 the status byte reads bit 0 packet-ready and bit 1 data toggle, and the other bits read 0.
- R3: With auto-arm at 1, a FIFO write that brings the byte count to exactly `max_pkt` sets packet-ready after that clock edge.
- R4: A packet shorter than `max_pkt` never sets packet-ready by itself. Writing the status byte with bit 0 at 1 sets it; writing bit 0 at 0 leaves it unchanged.
- R5: `ack_in` while packet-ready is 1 inverts the data toggle, clears packet-ready and zeroes the byte count. `ack_in` while packet-ready is 0 has no effect.
- R6: Writing the control byte with bit 3 at 1 inverts the data toggle, clears packet-ready and the byte count, and pulses `fifo_flush` for one cycle after the edge, whether or not a handshake arrived. The bit is not stored.
- R7: A status byte write changes the data toggle to bit 1 of the data only when `tgl_wr_en` is 1 in that cycle. Otherwise the toggle keeps its value.
- R8: `dma_req` is 1 exactly when DMA enable is 1 and packet-ready is 0.
- R9: With DMA enable 1 and mode 0, `irq` pulses for one cycle after each FIFO write that completes a full `max_pkt` packet, and after the write that completes the transfer.
- R10: With DMA enable 1 and mode 1, `irq` pulses only after the FIFO write that brings the transfer byte count to `xfer_len`. The transfer count returns to 0 at that point and while DMA enable is 0.
- R11: `ep_is_tx` equals the direction bit when `shared_fifo` is 1, and is 1 otherwise.
- R12: When a handshake or forced toggle coincides with a FIFO write or a packet-ready set, the clear wins: packet-ready ends at 0 and the byte count at 0, and that write is not counted. A status toggle write enabled by `tgl_wr_en` overrides the inversion from a handshake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register select: 0 status, 1 control |
| csr_wdata | input | 8 | Register write data |
| tgl_wr_en | input | 1 | Permits a toggle write in this status write |
| csr_rdata | output | 8 | Register read data for `csr_addr` |
| fifo_wr | input | 1 | One byte written into the transmit FIFO |
| max_pkt | input | MAXP_W | Maximum packet size in bytes |
| xfer_len | input | XFER_W | Bytes per DMA transfer |
| ack_in | input | 1 | Handshake received for the armed packet |
| shared_fifo | input | 1 | Endpoint FIFO is shared by both directions |
| pkt_rdy | output | 1 | Packet armed for transmission |
| data_tgl | output | 1 | Current data toggle |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | One-cycle interrupt pulse |
| ep_is_tx | output | 1 | Endpoint direction is transmit |

## Verification
Register state is due one clock after the edge that samples a stimulus. This covers packet-ready, the toggle, the control bits and the byte counts. `fifo_flush` and `irq` are registered pulses that are high only during the cycle after that edge. `csr_rdata`, `dma_req` and `ep_is_tx` follow the registers and inputs combinationally within the same cycle. The bench drives inputs shortly after each rising edge and steps its reference model on the rising edge, so the model sees the same sampled values as the design. It compares every output on the falling edge, and its directed checks sample right after the edge whose effect they test.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;
  localparam int unsigned CSR_W = 8;
  localparam logic SEL_STAT = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
  // control byte positions (software visible)
  localparam int unsigned C_AUTO  = 7;
  localparam int unsigned C_DIR   = 5;
  localparam int unsigned C_DMAEN = 4;
  localparam int unsigned C_FORCE = 3;
  localparam int unsigned C_MODE  = 2;
  // status byte positions
  localparam int unsigned S_RDY   = 0;
  localparam int unsigned S_TGL   = 1;

  typedef struct packed {
    logic autoarm;
    logic dir_tx;
    logic dma_en;
    logic dma_whole;
  } txep_ctrl_t;
endpackage

// File: rtl/txep_rst_sync.sv
module txep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/txep_ctrl_reg.sv
module txep_ctrl_reg
  import usb_txep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [CSR_W-1:0] wdata,
  output txep_ctrl_t       ctrl,
  output logic             force_tgl,
  output logic             fifo_flush
);
  txep_ctrl_t ctrl_q, ctrl_d;
  logic       flush_q, flush_d;

  assign force_tgl = wr_ctrl & wdata[C_FORCE];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.autoarm   = wdata[C_AUTO];
      ctrl_d.dir_tx    = wdata[C_DIR];
      ctrl_d.dma_en    = wdata[C_DMAEN];
      ctrl_d.dma_whole = wdata[C_MODE];
    end
    flush_d = force_tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      flush_q <= flush_d;
    end
  end

  assign ctrl       = ctrl_q;
  assign fifo_flush = flush_q;

  p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_tgl |=> fifo_flush);
  p_flush_only_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !force_tgl |=> !fifo_flush);
endmodule

// File: rtl/txep_pkt_track.sv
module txep_pkt_track #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_wr,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             autoarm,
  input  logic             ack_in,
  input  logic             force_tgl,
  input  logic             wr_stat,
  input  logic             wdata_rdy,
  input  logic             wdata_tgl,
  input  logic             tgl_wr_en,
  output logic             pkt_rdy,
  output logic             data_tgl,
  output logic             pkt_fill
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             rdy_q, rdy_d, tgl_q, tgl_d;
  logic             hit, ack_ok, clr, manual_set, auto_set, tgl_wr;
  logic             cnt_en, rdy_en, tgl_en;

  assign cnt_inc    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign hit        = (cnt_inc == {1'b0, max_pkt});
  assign pkt_fill   = fifo_wr & hit;
  assign ack_ok     = ack_in & rdy_q;
  assign clr        = force_tgl | ack_ok;
  assign manual_set = wr_stat & wdata_rdy;
  assign auto_set   = autoarm & pkt_fill;
  assign tgl_wr     = wr_stat & tgl_wr_en;

  assign cnt_en = clr | fifo_wr;
  assign rdy_en = clr | manual_set | auto_set;
  assign tgl_en = clr | tgl_wr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (fifo_wr && cnt_q != CNT_MAX) cnt_d = cnt_inc[CNT_W-1:0];

    rdy_d = rdy_q;
    if (clr)                         rdy_d = 1'b0;
    else if (manual_set || auto_set) rdy_d = 1'b1;

    tgl_d = tgl_q;
    if (tgl_wr)   tgl_d = wdata_tgl;
    else if (clr) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rdy_en) rdy_q <= rdy_d;
      if (tgl_en) tgl_q <= tgl_d;
    end
  end

  assign pkt_rdy  = rdy_q;
  assign data_tgl = tgl_q;

  p_auto_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    auto_set && !clr |=> pkt_rdy);
  p_short_no_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr && !hit && !pkt_rdy && !manual_set |=> !pkt_rdy);
  p_ack_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_in && pkt_rdy && !tgl_wr |=> data_tgl != $past(data_tgl));
  p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_in && !pkt_rdy && !force_tgl && !tgl_wr |=> $stable(data_tgl));
  p_tgl_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !tgl_wr_en && !clr |=> $stable(data_tgl));
  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pkt_rdy && cnt_q == '0);
endmodule

// File: rtl/txep_dma_irq.sv
module txep_dma_irq #(
  parameter int unsigned XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              dma_whole,
  input  logic              pkt_rdy,
  input  logic              fifo_wr,
  input  logic              pkt_fill,
  input  logic [XFER_W-1:0] xfer_len,
  output logic              dma_req,
  output logic              irq
);
  localparam logic [XFER_W-1:0] XCNT_MAX = '1;

  logic [XFER_W-1:0] xcnt_q, xcnt_d;
  logic [XFER_W:0]   xinc;
  logic              xdone, pkt_evt, irq_q, irq_d, xcnt_en;

  assign xinc    = {1'b0, xcnt_q} + {{XFER_W{1'b0}}, 1'b1};
  assign xdone   = dma_en & fifo_wr & (xinc == {1'b0, xfer_len});
  assign pkt_evt = dma_en & pkt_fill;
  assign xcnt_en = !dma_en || fifo_wr;

  always_comb begin
    xcnt_d = xcnt_q;
    if (!dma_en || xdone)                xcnt_d = '0;
    else if (fifo_wr && xcnt_q != XCNT_MAX) xcnt_d = xinc[XFER_W-1:0];
    irq_d = dma_whole ? xdone : (xdone | pkt_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (xcnt_en) xcnt_q <= xcnt_d;
      irq_q <= irq_d;
    end
  end

  assign dma_req = dma_en & ~pkt_rdy;
  assign irq     = irq_q;

  p_req_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy |-> !dma_req);
  p_pkt_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_whole && pkt_evt |=> irq);
  p_whole_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_whole && !xdone |=> !irq);
  p_xfer_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xdone |=> xcnt_q == '0);
endmodule

// File: rtl/usb_txep_ctrl.sv
module usb_txep_ctrl
  import usb_txep_pkg::*;
#(
  parameter int unsigned MAXP_W = 11,
  parameter int unsigned XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_addr,
  input  logic [7:0]        csr_wdata,
  input  logic              tgl_wr_en,
  output logic [7:0]        csr_rdata,
  input  logic              fifo_wr,
  input  logic [MAXP_W-1:0] max_pkt,
  input  logic [XFER_W-1:0] xfer_len,
  input  logic              ack_in,
  input  logic              shared_fifo,
  output logic              pkt_rdy,
  output logic              data_tgl,
  output logic              fifo_flush,
  output logic              dma_req,
  output logic              irq,
  output logic              ep_is_tx
);
  logic       rst_i_n, wr_ctrl, wr_stat, force_tgl, pkt_fill;
  txep_ctrl_t ctrl;

  assign wr_ctrl = csr_wr & (csr_addr == SEL_CTRL);
  assign wr_stat = csr_wr & (csr_addr == SEL_STAT);

  txep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  txep_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_ctrl    (wr_ctrl),
    .wdata      (csr_wdata),
    .ctrl       (ctrl),
    .force_tgl  (force_tgl),
    .fifo_flush (fifo_flush)
  );

  txep_pkt_track #(.CNT_W(MAXP_W)) u_pkt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fifo_wr   (fifo_wr),
    .max_pkt   (max_pkt),
    .autoarm   (ctrl.autoarm),
    .ack_in    (ack_in),
    .force_tgl (force_tgl),
    .wr_stat   (wr_stat),
    .wdata_rdy (csr_wdata[S_RDY]),
    .wdata_tgl (csr_wdata[S_TGL]),
    .tgl_wr_en (tgl_wr_en),
    .pkt_rdy   (pkt_rdy),
    .data_tgl  (data_tgl),
    .pkt_fill  (pkt_fill)
  );

  txep_dma_irq #(.XFER_W(XFER_W)) u_dma (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .dma_en    (ctrl.dma_en),
    .dma_whole (ctrl.dma_whole),
    .pkt_rdy   (pkt_rdy),
    .fifo_wr   (fifo_wr),
    .pkt_fill  (pkt_fill),
    .xfer_len  (xfer_len),
    .dma_req   (dma_req),
    .irq       (irq)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == SEL_CTRL) begin
      csr_rdata[C_AUTO]  = ctrl.autoarm;
      csr_rdata[C_DIR]   = ctrl.dir_tx;
      csr_rdata[C_DMAEN] = ctrl.dma_en;
      csr_rdata[C_MODE]  = ctrl.dma_whole;
    end else begin
      csr_rdata[S_RDY]   = pkt_rdy;
      csr_rdata[S_TGL]   = data_tgl;
    end
  end

  assign ep_is_tx = shared_fifo ? ctrl.dir_tx : 1'b1;

  p_dir_unshared_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !shared_fifo |-> ep_is_tx);
endmodule

// File: tb/usb_txep_ctrl_bench.sv
module usb_txep_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr, csr_addr, tgl_wr_en, fifo_wr, ack_in, shared_fifo;
  logic [7:0]  csr_wdata;
  logic [10:0] max_pkt;
  logic [15:0] xfer_len;
  logic [7:0]  csr_rdata;
  logic        pkt_rdy, data_tgl, fifo_flush, dma_req, irq, ep_is_tx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usb_txep_ctrl u_usb_txep_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .tgl_wr_en(tgl_wr_en), .csr_rdata(csr_rdata),
    .fifo_wr(fifo_wr), .max_pkt(max_pkt), .xfer_len(xfer_len),
    .ack_in(ack_in), .shared_fifo(shared_fifo), .pkt_rdy(pkt_rdy),
    .data_tgl(data_tgl), .fifo_flush(fifo_flush), .dma_req(dma_req),
    .irq(irq), .ep_is_tx(ep_is_tx)
  );

  // behavioural reference model
  bit m_auto = 0, m_dir = 0, m_dmaen = 0, m_mode = 0;
  bit m_rdy = 0, m_tgl = 0, m_irq = 0, m_flush = 0;
  int m_cnt = 0, m_x = 0;
  bit s0 = 0, s1 = 0;

  always @(posedge clk) begin
    bit in_rst, frc, clr, full, xend, man;
    in_rst = !s1 || !rst_n;
    if (!rst_n) begin s0 = 0; s1 = 0; end
    else begin s1 = s0; s0 = 1; end
    if (in_rst) begin
      m_auto = 0; m_dir = 0; m_dmaen = 0; m_mode = 0;
      m_rdy = 0; m_tgl = 0; m_irq = 0; m_flush = 0; m_cnt = 0; m_x = 0;
    end else begin
      frc  = csr_wr && csr_addr && csr_wdata[3];
      clr  = frc || (ack_in && m_rdy);
      full = fifo_wr && (m_cnt + 1 == int'(max_pkt));
      xend = m_dmaen && fifo_wr && (m_x + 1 == int'(xfer_len));
      man  = csr_wr && !csr_addr && csr_wdata[0];
      m_irq   = m_mode ? xend : (xend || (m_dmaen && full));
      m_flush = frc;
      if (csr_wr && !csr_addr && tgl_wr_en) m_tgl = csr_wdata[1];
      else if (clr) m_tgl = !m_tgl;
      if (clr) m_rdy = 0;
      else if (man || (m_auto && full)) m_rdy = 1;
      if (clr) m_cnt = 0;
      else if (fifo_wr && m_cnt < 2047) m_cnt = m_cnt + 1;
      if (!m_dmaen || xend) m_x = 0;
      else if (fifo_wr && m_x < 65535) m_x = m_x + 1;
      if (csr_wr && csr_addr) begin
        m_auto = csr_wdata[7]; m_dir = csr_wdata[5];
        m_dmaen = csr_wdata[4]; m_mode = csr_wdata[2];
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) if (!finished) begin
    int exp_rd;
    exp_rd = csr_addr ? {m_auto, 1'b0, m_dir, m_dmaen, 1'b0, m_mode, 2'b00}
                      : {6'b0, m_tgl, m_rdy};
    chk("R2 csr_rdata", csr_rdata, exp_rd);
    chk("R3 pkt_rdy", pkt_rdy, m_rdy);
    chk("R5 data_tgl", data_tgl, m_tgl);
    chk("R6 fifo_flush", fifo_flush, m_flush);
    chk("R8 dma_req", dma_req, m_dmaen && !m_rdy);
    chk("R9 irq", irq, m_irq);
    chk("R11 ep_is_tx", ep_is_tx, shared_fifo ? m_dir : 1);
  end

  task automatic cyc;
    @(posedge clk); #2;
    csr_wr = 0; fifo_wr = 0; ack_in = 0; tgl_wr_en = 0;
  endtask

  task automatic wr(bit a, logic [7:0] d, bit te);
    csr_wr = 1; csr_addr = a; csr_wdata = d; tgl_wr_en = te; cyc();
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin fifo_wr = 1; cyc(); end
  endtask

  task automatic ack;
    ack_in = 1; cyc();
  endtask

  task automatic rd(bit a, int exp, string tag);
    csr_addr = a; #1; chk(tag, csr_rdata, exp);
  endtask

  initial begin
    int cycles = 0;
    while (!finished) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: got %0d expected below 100000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1;
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; csr_wr = 0; csr_addr = 0; csr_wdata = 0; tgl_wr_en = 0;
    fifo_wr = 0; ack_in = 0; shared_fifo = 0; max_pkt = 11'd8; xfer_len = 16'd20;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();
    // R1 reset state
    rd(1, 0, "R1 control after reset");
    rd(0, 0, "R1 status after reset");
    chk("R1 dma_req", dma_req, 0);
    chk("R1 ep_is_tx", ep_is_tx, 1);
    // R2 layout, reserved bits; bit 3 also forces a toggle (R6)
    wr(1, 8'hFF, 0);
    rd(1, 8'hB4, "R2 control readback");
    chk("R6 flush after force", fifo_flush, 1);
    rd(0, 8'h02, "R6 toggle flipped");
    shared_fifo = 1; #1;
    chk("R11 shared tx", ep_is_tx, 1);
    wr(1, 8'h00, 0);
    chk("R11 shared rx", ep_is_tx, 0);
    shared_fifo = 0; #1;
    chk("R11 unshared", ep_is_tx, 1);
    // R3 auto-arm on full packet
    wr(1, 8'h80, 0);
    push(7);
    chk("R3 not yet", pkt_rdy, 0);
    push(1);
    chk("R3 armed at max", pkt_rdy, 1);
    ack();
    chk("R5 ack clears", pkt_rdy, 0);
    rd(0, 8'h01 << 1 & 8'h00, "R5 toggle back to 0");
    // R4 short packet and manual set
    push(5);
    chk("R4 short not armed", pkt_rdy, 0);
    wr(0, 8'h00, 0);
    chk("R4 write 0 no set", pkt_rdy, 0);
    wr(0, 8'h01, 0);
    chk("R4 manual set", pkt_rdy, 1);
    ack();
    rd(0, 8'h02, "R5 toggle after ack");
    ack();
    rd(0, 8'h02, "R5 idle ack ignored");
    // R7 guarded toggle write
    wr(0, 8'h00, 0);
    rd(0, 8'h02, "R7 toggle write dropped");
    wr(0, 8'h00, 1);
    rd(0, 8'h00, "R7 toggle write taken");
    // R6 forced toggle with packet armed
    wr(0, 8'h01, 0);
    wr(1, 8'h88, 0);
    chk("R6 forced clears rdy", pkt_rdy, 0);
    rd(1, 8'h80, "R6 force bit reads 0");
    // R12 ack and write in same cycle
    wr(0, 8'h01, 0);
    ack_in = 1; fifo_wr = 1; cyc();
    chk("R12 clear wins", pkt_rdy, 0);
    push(7);
    chk("R12 write discarded", pkt_rdy, 0);
    push(1);
    chk("R12 arm at 8", pkt_rdy, 1);
    csr_wr = 1; csr_addr = 0; csr_wdata = 8'h00; tgl_wr_en = 1; ack_in = 1; cyc();
    rd(0, 8'h00, "R12 toggle write beats ack");
    // R8/R9 DMA per-packet interrupts
    wr(1, 8'h90, 0);
    chk("R8 req while idle", dma_req, 1);
    push(8);
    chk("R9 irq per packet", irq, 1);
    chk("R8 req drops", dma_req, 0);
    cyc();
    chk("R9 irq one cycle", irq, 0);
    ack(); push(8);
    chk("R9 second packet irq", irq, 1);
    ack(); push(4);
    chk("R9 transfer end irq", irq, 1);
    wr(0, 8'h01, 0); ack();
    // R10 whole-transfer mode
    wr(1, 8'h94, 0);
    push(8);
    chk("R10 no per-packet irq", irq, 0);
    ack(); push(8);
    chk("R10 still quiet", irq, 0);
    ack(); push(4);
    chk("R10 irq at transfer end", irq, 1);
    wr(0, 8'h01, 0); ack();
    wr(1, 8'h04, 0);
    push(3);
    chk("R10 disabled no irq", irq, 0);
    repeat (3) cyc();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule